// File: doc/BRIEF.md
# Prioritized Two-Output Interrupt Controller

This block collects thirty-two interrupt request lines and presents them to a processor as two outputs: a normal request and a fast request. A 16-bit register interface configures each line separately. The configuration gives the line a five-bit priority, selects whether the line is sensed on a rising edge or by its level, and picks the output it is routed to. Two pending words record the requests and two mask words gate them.

Each output runs its own arbitration over the unmasked pending lines routed to it. The winner is latched and its index is published in a winner register. The output then stays asserted, and the winner stays fixed, until software writes that output's acknowledge bit. The acknowledge releases the output for at least one cycle. It also clears the pending bit of an edge-sensed winner, and a fresh arbitration follows.

Top module: `intc_top`

## Requirements
- R1: After reset both mask words read 0xFFFF. Both pending words read 0. Both winner registers read 0, and both outputs are low.
- R2: The mask word at byte offset 0x08 covers lines 0–15 and the one at 0x0A covers lines 16–31, bit k standing for line k of that half. A 1 keeps its line out of arbitration and a 0 lets it take part. A pending line that is masked never asserts an output.
- R3: Line n has a configuration register at offset 0x20 + 2·n. Bit 0 set routes the line to the fast output, and clear routes it to the normal output. Bit 1 set selects rising-edge sensing, and clear selects level sensing. Bits 6:2 hold the priority. Bits 15:7 read back as 0.
- R4: The pending word at 0x00 holds lines 0–15 and the one at 0x02 holds lines 16–31. An edge-sensed line's bit is set one clock edge after a 0→1 input change and then stays set. A level-sensed line's bit copies its input with one clock edge of delay.
- R5: A write to a pending word clears each bit written as 0 and leaves each bit written as 1 unchanged. A new rising edge in the same cycle keeps its bit set.
- R6: Among the eligible lines, the smallest priority value wins. On equal priority, the lower line index wins.
- R7: The winner index of the normal output is read at 0x10, and that of the fast output at 0x12, in bits 4:0. Each reads 0 while its output has no winner.
- R8: An output with no winner rises on the clock edge after a line becomes pending and eligible, which is two edges after the input edge. While asserted, the output and its winner index hold even if the line drops or is masked.
- R9: In the control register at 0x14, writing bit 0 as 1 acknowledges the normal output and writing bit 1 as 1 acknowledges the fast output. An acknowledged output is low for at least the following cycle. An acknowledge sent to an output that has no winner has no effect. The control register always reads 0.
- R10: On acknowledge, an edge-sensed winner's pending bit is cleared. A level-sensed winner's bit keeps following its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 32 | Interrupt request lines |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Register reads are combinational, so a read reflects the state left by the last clock edge. A register write takes effect on the edge that samples it. A pending bit follows its input one edge later. An output rises one further edge after that, which is two edges after the input changed. After an acknowledge, the output is low on the next edge, and a waiting line is presented on the edge after. The bench applies stimulus at the falling edge and updates a behavioural model on every rising edge. It compares both outputs with the model at each falling edge, and it reads registers one nanosecond after a falling edge, once all of these delays have passed.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int PRIO_W = 5;
  localparam int ADDR_W = 8;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              edge_sel;
    logic              to_fiq;
  } lvl_t;

  localparam logic [ADDR_W-1:0] OFS_PEND    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_IRQ_NUM = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_FIQ_NUM = 8'h12;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_LVL     = 8'h20;
endpackage

// File: rtl/intc_pend.sv
`timescale 1ns/1ps
module intc_pend #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] edge_i,
  input  logic [N_SRC-1:0] wclr_i,
  input  logic [N_SRC-1:0] aclr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] src_q;
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] pend_n;
  logic [N_SRC-1:0] rise;

  assign rise = src_i & ~src_q;

  // edge lines: sticky, cleared by software or by acknowledge; a new edge wins
  // level lines: registered copy of the input
  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      if (edge_i[i])
        pend_n[i] = (pend_q[i] & ~wclr_i[i] & ~aclr_i[i]) | rise[i];
      else
        pend_n[i] = src_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= pend_n;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/intc_regs.sv
`timescale 1ns/1ps
module intc_regs
  import intc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 16,
  parameter int ID_W   = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    wr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [ID_W-1:0]         irq_num_i,
  input  logic [ID_W-1:0]         fiq_num_i,
  output logic [N_SRC-1:0]        mask_o,
  output lvl_t [N_SRC-1:0]        lvl_o,
  output logic [N_SRC-1:0]        wclr_o,
  output logic [1:0]              ack_o,
  output logic [DATA_W-1:0]       rdata_o
);
  localparam int NWORD    = N_SRC / DATA_W;
  localparam int LVL_BITS = $bits(lvl_t);

  // mask words and pending-clear decode, one per half
  for (genvar w = 0; w < NWORD; w++) begin : g_word
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(int'(OFS_MASK) + 2 * w);
    localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(int'(OFS_PEND) + 2 * w);
    logic              m_en;
    logic [DATA_W-1:0] m_n;
    logic [DATA_W-1:0] m_q;

    assign m_en = wr_i && (addr_i == MASK_A);
    assign m_n  = wdata_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    m_q <= '1;
      else if (m_en) m_q <= m_n;
    end

    assign mask_o[w*DATA_W +: DATA_W] = m_q;
    assign wclr_o[w*DATA_W +: DATA_W] =
      (wr_i && (addr_i == PEND_A)) ? ~wdata_i : '0;
  end

  // per-line configuration registers
  for (genvar i = 0; i < N_SRC; i++) begin : g_lvl
    localparam logic [ADDR_W-1:0] LVL_A = ADDR_W'(int'(OFS_LVL) + 2 * i);
    logic l_en;
    lvl_t l_n;
    lvl_t l_q;

    assign l_en = wr_i && (addr_i == LVL_A);
    assign l_n  = lvl_t'(wdata_i[LVL_BITS-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    l_q <= '0;
      else if (l_en) l_q <= l_n;
    end

    assign lvl_o[i] = l_q;
  end

  // acknowledge strobes are not stored: control reads as zero
  assign ack_o = (wr_i && (addr_i == OFS_CTRL)) ? wdata_i[1:0] : 2'b00;

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NWORD; w++) begin
      if (addr_i == ADDR_W'(int'(OFS_PEND) + 2 * w)) rdata_o = pend_i[w*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(int'(OFS_MASK) + 2 * w)) rdata_o = mask_o[w*DATA_W +: DATA_W];
    end
    if (addr_i == OFS_IRQ_NUM) rdata_o = DATA_W'(irq_num_i);
    if (addr_i == OFS_FIQ_NUM) rdata_o = DATA_W'(fiq_num_i);
    for (int i = 0; i < N_SRC; i++) begin
      if (addr_i == ADDR_W'(int'(OFS_LVL) + 2 * i)) rdata_o = DATA_W'(lvl_o[i]);
    end
  end
endmodule

// File: rtl/intc_arb.sv
`timescale 1ns/1ps
module intc_arb
  import intc_pkg::*;
#(
  parameter int N_SRC   = 32,
  parameter int ID_W    = 5,
  parameter bit FIQ_SEL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] mask_i,
  input  lvl_t [N_SRC-1:0] lvl_i,
  input  logic             ack_i,
  output logic             valid_o,
  output logic [ID_W-1:0]  num_o,
  output logic [N_SRC-1:0] aclr_o
);
  logic [N_SRC-1:0]  elig;
  logic              found;
  logic [PRIO_W-1:0] best_p;
  logic [ID_W-1:0]   best_id;
  logic              valid_q, valid_n;
  logic [ID_W-1:0]   num_q, num_n;
  logic              upd;

  always_comb begin
    for (int i = 0; i < N_SRC; i++)
      elig[i] = pend_i[i] & ~mask_i[i] & (lvl_i[i].to_fiq == FIQ_SEL);
  end

  // ascending scan with strict compare: ties stay with the lower index
  always_comb begin
    found   = 1'b0;
    best_p  = '1;
    best_id = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!found || (lvl_i[i].prio < best_p))) begin
        found   = 1'b1;
        best_p  = lvl_i[i].prio;
        best_id = ID_W'(i);
      end
    end
  end

  assign upd = !valid_q || ack_i;

  always_comb begin
    if (!valid_q) begin
      valid_n = found;
      num_n   = found ? best_id : '0;
    end else begin
      valid_n = 1'b0;
      num_n   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      num_q   <= '0;
    end else if (upd) begin
      valid_q <= valid_n;
      num_q   <= num_n;
    end
  end

  always_comb begin
    aclr_o = '0;
    if (valid_q && ack_i && lvl_i[num_q].edge_sel) aclr_o[num_q] = 1'b1;
  end

  assign valid_o = valid_q;
  assign num_o   = num_q;
endmodule

// File: rtl/intc_top.sv
`timescale 1ns/1ps
module intc_top
  import intc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int ID_W  = $clog2(N_SRC);
  localparam int N_OUT = 2;

  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] mask_q;
  lvl_t [N_SRC-1:0] lvl;
  logic [N_SRC-1:0] wclr;
  logic [N_SRC-1:0] edge_v;
  logic [N_OUT-1:0] ack;
  logic [N_OUT-1:0] valid;
  logic [ID_W-1:0]  num  [N_OUT];
  logic [N_SRC-1:0] aclr [N_OUT];
  logic [N_SRC-1:0] aclr_all;
  logic [ID_W-1:0]  irq_num, fiq_num;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) edge_v[i] = lvl[i].edge_sel;
  end

  intc_pend #(.N_SRC(N_SRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_q),
    .src_i  (src_i),
    .edge_i (edge_v),
    .wclr_i (wclr),
    .aclr_i (aclr_all),
    .pend_o (pend)
  );

  intc_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ID_W(ID_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q),
    .addr_i    (reg_addr),
    .wr_i      (reg_wr),
    .wdata_i   (reg_wdata),
    .pend_i    (pend),
    .irq_num_i (irq_num),
    .fiq_num_i (fiq_num),
    .mask_o    (mask_q),
    .lvl_o     (lvl),
    .wclr_o    (wclr),
    .ack_o     (ack),
    .rdata_o   (reg_rdata)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_arb
    intc_arb #(.N_SRC(N_SRC), .ID_W(ID_W), .FIQ_SEL(k == 1)) u_arb (
      .clk     (clk),
      .rst_n   (rst_q),
      .pend_i  (pend),
      .mask_i  (mask_q),
      .lvl_i   (lvl),
      .ack_i   (ack[k]),
      .valid_o (valid[k]),
      .num_o   (num[k]),
      .aclr_o  (aclr[k])
    );
  end

  assign aclr_all = aclr[0] | aclr[1];
  assign irq_num  = num[0];
  assign fiq_num  = num[1];
  assign irq_o    = valid[0];
  assign fiq_o    = valid[1];
endmodule

// File: rtl/intc_chk.sv
`timescale 1ns/1ps
module intc_chk #(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 16,
  parameter int ID_W   = 5
) (
  input logic              clk,
  input logic              rst_q,
  input logic [7:0]        reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [ID_W-1:0]   irq_num,
  input logic [ID_W-1:0]   fiq_num,
  input logic [N_SRC-1:0]  mask_q
);
  logic ack_irq, ack_fiq;
  logic [N_SRC-1:0] mask_d;

  assign ack_irq = reg_wr && (reg_addr == 8'h14) && reg_wdata[0];
  assign ack_fiq = reg_wr && (reg_addr == 8'h14) && reg_wdata[1];

  always_ff @(posedge clk) mask_d <= mask_q;

  // R9
  irq_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (ack_irq && irq_o) |=> !irq_o);
  // R9
  fiq_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (ack_fiq && fiq_o) |=> !fiq_o);
  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (irq_o && !ack_irq) |=> (irq_o && $stable(irq_num)));
  // R8
  fiq_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (fiq_o && !ack_fiq) |=> (fiq_o && $stable(fiq_num)));
  // R7
  irq_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !irq_o |-> (irq_num == '0));
  // R7
  fiq_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !fiq_o |-> (fiq_num == '0));
  // R9
  ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (reg_addr == 8'h14) |-> (reg_rdata == '0));
  // R2
  irq_mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(irq_o) |-> !mask_d[irq_num]);
endmodule

bind intc_top intc_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .irq_num   (irq_num),
  .fiq_num   (fiq_num),
  .mask_q    (mask_q)
);

// File: tb/test_intc_top.sv
`timescale 1ns/1ps
module test_intc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_o, fiq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  intc_top i_intc_top (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // behavioural reference model
  logic [31:0] m_pend, m_mask, m_srcq, m_edge, m_fiq;
  logic [4:0]  m_prio [32];
  bit          m_val  [2];
  int          m_num  [2];
  int          rcnt = 0;

  always @(posedge clk) begin
    logic [31:0] wclr, aclr, npend;
    bit          fnd;
    int          bid;
    int          bp;
    if (!rst_n) rcnt = 0;
    if (!rst_n || rcnt < 2) begin
      if (rst_n) rcnt++;
      m_pend = '0; m_mask = '1; m_srcq = '0; m_edge = '0; m_fiq = '0;
      for (int i = 0; i < 32; i++) m_prio[i] = '0;
      for (int k = 0; k < 2; k++) begin m_val[k] = 0; m_num[k] = 0; end
    end else begin
      aclr = '0;
      for (int k = 0; k < 2; k++) begin
        fnd = 0; bid = 0; bp = 99;
        for (int i = 0; i < 32; i++)
          if (m_pend[i] && !m_mask[i] && (int'(m_fiq[i]) == k) && int'(m_prio[i]) < bp) begin
            fnd = 1; bid = i; bp = int'(m_prio[i]);
          end
        if (!m_val[k]) begin
          m_val[k] = fnd; m_num[k] = fnd ? bid : 0;
        end else if (reg_wr && reg_addr == 8'h14 && reg_wdata[k]) begin
          if (m_edge[m_num[k]]) aclr[m_num[k]] = 1'b1;
          m_val[k] = 0; m_num[k] = 0;
        end
      end
      wclr = '0;
      if (reg_wr && reg_addr == 8'h00) wclr[15:0]  = ~reg_wdata;
      if (reg_wr && reg_addr == 8'h02) wclr[31:16] = ~reg_wdata;
      for (int i = 0; i < 32; i++)
        npend[i] = m_edge[i] ? ((m_pend[i] & ~wclr[i] & ~aclr[i]) | (src_i[i] & ~m_srcq[i]))
                             : src_i[i];
      m_pend = npend;
      m_srcq = src_i;
      if (reg_wr && reg_addr == 8'h08) m_mask[15:0]  = reg_wdata;
      if (reg_wr && reg_addr == 8'h0A) m_mask[31:16] = reg_wdata;
      for (int i = 0; i < 32; i++)
        if (reg_wr && reg_addr == 8'(32 + 2 * i)) begin
          m_prio[i] = reg_wdata[6:2]; m_edge[i] = reg_wdata[1]; m_fiq[i] = reg_wdata[0];
        end
    end
  end

  function automatic logic [15:0] exp_rd(logic [7:0] a);
    logic [15:0] r;
    r = '0;
    case (a)
      8'h00: r = m_pend[15:0];
      8'h02: r = m_pend[31:16];
      8'h08: r = m_mask[15:0];
      8'h0A: r = m_mask[31:16];
      8'h10: r = 16'(m_num[0]);
      8'h12: r = 16'(m_num[1]);
      default: if (a >= 8'h20 && a < 8'h60 && !a[0])
                 r = {9'b0, m_prio[(a - 8'h20) >> 1], m_edge[(a - 8'h20) >> 1], m_fiq[(a - 8'h20) >> 1]};
    endcase
    return r;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle output comparison against the model (R8, R9 timing)
  always @(negedge clk) begin
    if (rst_n && rcnt >= 2 && !done) begin
      check(irq_o == m_val[0], "R8/R9 irq_o vs model", int'(irq_o), int'(m_val[0]));
      check(fiq_o == m_val[1], "R8/R9 fiq_o vs model", int'(fiq_o), int'(m_val[1]));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // reads at the current falling edge plus 1 ns; compares to model and hand value
  task automatic rd(logic [7:0] a, logic [15:0] hand, string tag);
    reg_addr = a;
    #1;
    check(reg_rdata == exp_rd(a), {tag, " model"}, int'(reg_rdata), int'(exp_rd(a)));
    check(reg_rdata == hand, {tag, " hand"}, int'(reg_rdata), int'(hand));
  endtask

  task automatic outs(bit ei, bit ef, string tag);
    check(irq_o == ei, {tag, " irq_o"}, int'(irq_o), int'(ei));
    check(fiq_o == ef, {tag, " fiq_o"}, int'(fiq_o), int'(ef));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(4 * 50000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    rd(8'h08, 16'hFFFF, "R1 mask lo");
    rd(8'h0A, 16'hFFFF, "R1 mask hi");
    rd(8'h00, 16'h0000, "R1 pend lo");
    rd(8'h02, 16'h0000, "R1 pend hi");
    rd(8'h10, 16'h0000, "R1 irq num");
    rd(8'h12, 16'h0000, "R1 fiq num");
    outs(0, 0, "R1");

    // R3 configuration
    wr(8'h20 + 2*5,  16'hFFFF); idle(1);
    rd(8'h20 + 2*5, 16'h007F, "R3 lvl readback");
    wr(8'h20 + 2*3,  16'h0010);   // prio 4, level, normal
    wr(8'h20 + 2*20, 16'h000B);   // prio 2, edge, fast
    wr(8'h20 + 2*7,  16'h000E);   // prio 3, edge, normal
    wr(8'h20 + 2*9,  16'h000E);
    wr(8'h20 + 2*1,  16'h001A);   // prio 6, edge, normal
    wr(8'h20 + 2*12, 16'h0002);   // prio 0, edge, normal
    wr(8'h20 + 2*13, 16'h0002);
    idle(1);
    rd(8'h20 + 2*20, 16'h000B, "R3 lvl fast edge");
    wr(8'h08, 16'hFD75);
    wr(8'h0A, 16'hFFEF);

    // level line 3
    src_i[3] = 1'b1; idle(2);
    outs(1, 0, "R8 rise two edges");
    rd(8'h10, 16'd3, "R7 irq winner");
    rd(8'h00, 16'h0008, "R4 level pending");
    src_i[3] = 1'b0; idle(3);
    outs(1, 0, "R8 hold after drop");
    rd(8'h10, 16'd3, "R8 winner held");
    rd(8'h00, 16'h0000, "R4 level follows");
    wr(8'h14, 16'h0001);
    outs(0, 0, "R9 drop after ack");
    rd(8'h10, 16'd0, "R7 zero idle");

    // edge line 20 on fast output
    src_i[20] = 1'b1; idle(1); src_i[20] = 1'b0; idle(2);
    rd(8'h02, 16'h0010, "R4 edge sticky");
    outs(0, 1, "R8 fast");
    rd(8'h12, 16'd20, "R7 fiq winner");
    wr(8'h14, 16'h0002);
    outs(0, 0, "R9 fast drop");
    rd(8'h02, 16'h0000, "R10 auto clear");

    // priority and tie order
    src_i[1] = 1'b1; src_i[7] = 1'b1; src_i[9] = 1'b1; idle(1);
    src_i[1] = 1'b0; src_i[7] = 1'b0; src_i[9] = 1'b0; idle(2);
    rd(8'h10, 16'd7, "R6 tie lower index");
    wr(8'h14, 16'h0001);
    outs(0, 0, "R9 gap");
    idle(1);
    rd(8'h10, 16'd9, "R6 next");
    wr(8'h14, 16'h0001); idle(1);
    rd(8'h10, 16'd1, "R6 lowest last");
    wr(8'h14, 16'h0001); idle(1);
    outs(0, 0, "R10 all served");
    rd(8'h00, 16'h0000, "R10 pend empty");

    // masking
    src_i[12] = 1'b1; idle(1); src_i[12] = 1'b0; idle(3);
    outs(0, 0, "R2 masked");
    rd(8'h00, 16'h1000, "R2 pending while masked");
    wr(8'h08, 16'hED75); idle(1);
    rd(8'h10, 16'd12, "R2 unmasked wins");
    wr(8'h14, 16'h0001);
    wr(8'h08, 16'hFD75); idle(1);

    // pending clear by write
    src_i[12] = 1'b1; src_i[13] = 1'b1; idle(1);
    src_i[12] = 1'b0; src_i[13] = 1'b0; idle(2);
    rd(8'h00, 16'h3000, "R5 before clear");
    wr(8'h00, 16'hEFFF); idle(1);
    rd(8'h00, 16'h2000, "R5 zero clears one");
    wr(8'h00, 16'h0000); idle(1);
    rd(8'h00, 16'h0000, "R5 clear all");

    // new edge in same cycle as clear keeps bit
    @(negedge clk);
    src_i[13] = 1'b1; reg_addr = 8'h00; reg_wdata = 16'h0000; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; src_i[13] = 1'b0;
    rd(8'h00, 16'h2000, "R5 edge beats clear");

    // acknowledge with no winner
    wr(8'h14, 16'h0003); idle(1);
    outs(0, 0, "R9 idle ack");
    rd(8'h14, 16'h0000, "R9 ctrl reads zero");
    rd(8'h00, 16'h2000, "R9 idle ack no effect");
    idle(2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule